// File: doc/BRIEF.md
# Dual-Mode Input Capture Channel

This block is one timer channel that timestamps edges of an external digital input against a free-running time-base count supplied on a bus. It has two measurement modes, chosen by a 7-bit mode code. In pulse-width mode it records the count at a leading edge and at the following trailing edge. In period mode it records the count at consecutive edges of one chosen polarity. Software subtracts the two readable values to get the pulse width or the period.

Captures pass through an internal staging register. A leading edge in pulse-width mode, or any selected edge in period mode, loads the staging register. The older staging value then moves into the readable B register at the moment the A register is written. A flag reports that a valid pair is present. The flag is held back on the first capture after a mode change, because no earlier edge exists to pair with it. A read-order lock keeps a software read of A followed by B coherent. While the lock is active, A still updates, but the staging-to-B move is suppressed until B is read.

The input is expected to be already synchronised and filtered. Edges are found by comparing two registered samples of it, so a capture lands two clock edges after the input changes. The captured value is the count on the bus at that second edge.

Top module: `dual_capture_channel`

## Requirements
- R1: While reset is asserted, and after it, cap_a, cap_b and flag are all zero.
- R2: In pulse-width mode (mode_sel = 7'b0000100), a leading edge loads the count into the staging register only. cap_a, cap_b and flag do not change.
- R3: In pulse-width mode, a trailing edge that arrives before any leading edge has been captured since the last mode change is ignored.
- R4: In pulse-width mode, a trailing edge after a captured leading edge does three things in the same cycle: it loads the count into cap_a, moves the staged leading-edge count into cap_b, and sets flag.
- R5: In period mode (mode_sel = 7'b0000101), only edges of the selected polarity capture. pol = 1 selects rising edges and pol = 0 selects falling edges. Edges of the other polarity leave cap_a, cap_b and flag unchanged.
- R6: In period mode, each selected edge loads the count into cap_a and into the staging register, and moves the previous staging value into cap_b. The first capture after a mode change leaves flag clear. Every later capture sets it.
- R7: A capture that occurs while flag is already set still updates cap_a and cap_b, and flag stays set.
- R8: A pulse on rd_a blocks the staging-to-cap_b move, starting in the same cycle, until a pulse on rd_b. cap_a keeps updating while the block is active. After rd_b, moves resume.
- R9: A one on flag_clr clears flag on the next edge. If a flag-setting capture happens in the same cycle, flag is set.
- R10: Any change of mode_sel clears flag, the first-capture state and the read lock. No capture occurs in the cycle the change is seen.
- R11: Any mode code other than the two above performs no capture, and flag stays clear.
- R12: In pulse-width mode, pol selects the leading edge: rising when pol = 1, falling when pol = 0. The trailing edge is the opposite one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Synchronised, filtered input being measured |
| tbase | input | W | Time-base count bus |
| mode_sel | input | 7 | Mode code: 0000100 pulse width, 0000101 period |
| pol | input | 1 | Edge polarity select |
| flag_clr | input | 1 | Write-one-to-clear strobe for flag |
| rd_a | input | 1 | Strobe marking a software read of cap_a |
| rd_b | input | 1 | Strobe marking a software read of cap_b |
| cap_a | output | W | A capture register |
| cap_b | output | W | B capture register |
| flag | output | 1 | Valid-pair flag |

## Verification
Some behaviours are checked by assertions on every cycle:
- An unsupported mode leaves both capture registers still.
- flag holds unless it is cleared or the mode changes.
- flag only rises after a detected edge.
- cap_b is frozen while the read lock or rd_a is active.
- Opposite-polarity edges in period mode leave cap_a alone.
- A mode change clears the flag and the lock.

Other behaviours need the bench's ordered scenarios:
- Exact captured values.
- Pairing of the staged leading edge with the trailing edge.
- Suppression of the first flag in period mode.
- Ignoring a trailing edge before any leading edge.
- Set winning over clear.
- Resumption of B transfers after rd_b or after a mode change.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int MODE_W = 7;

    localparam logic [MODE_W-1:0] MODE_PULSE  = 7'b0000100;
    localparam logic [MODE_W-1:0] MODE_PERIOD = 7'b0000101;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PULSE,
        OP_PERIOD
    } op_e;

    function automatic op_e decode_mode(input logic [MODE_W-1:0] code);
        op_e op;
        case (code)
            MODE_PULSE:  op = OP_PULSE;
            MODE_PERIOD: op = OP_PERIOD;
            default:     op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic cur;
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.cur  = sig_in;
        smp_d.prev = smp_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign rise = smp_q.cur & ~smp_q.prev;
    assign fall = ~smp_q.cur & smp_q.prev;

endmodule

// File: rtl/cap_rdlock.sv
module cap_rdlock (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_a,
    input  logic rd_b,
    input  logic clr,
    output logic blk,
    output logic lock
);

    typedef struct packed {
        logic held;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (clr) begin
            lk_d.held = 1'b0;
        end else begin
            lk_d.held = (lk_q.held | rd_a) & ~rd_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    // An A read blocks the transfer in its own cycle, so an edge landing
    // together with the read cannot split the pair.
    assign blk  = lk_q.held | rd_a;
    assign lock = lk_q.held;

endmodule

// File: rtl/cap_core.sv
module cap_core
    import cap_pkg::*;
#(
    parameter int W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      tbase,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              pol,
    input  logic              rise,
    input  logic              fall,
    input  logic              flag_clr,
    input  logic              blk,
    output logic [W-1:0]      cap_a,
    output logic [W-1:0]      cap_b,
    output logic              flag,
    output logic              mode_chg
);

    typedef struct packed {
        logic [W-1:0]      a;
        logic [W-1:0]      b;
        logic [W-1:0]      stg;
        logic              flag;
        logic              armed;
        logic [MODE_W-1:0] mode;
    } core_t;

    core_t c_d, c_q;
    op_e   op;
    logic  lead, trail, set_flag, chg;

    always_comb begin
        c_d      = c_q;
        op       = decode_mode(mode_sel);
        chg      = (mode_sel != c_q.mode);
        lead     = pol ? rise : fall;
        trail    = pol ? fall : rise;
        set_flag = 1'b0;
        c_d.mode = mode_sel;

        if (chg) begin
            c_d.armed = 1'b0;
        end else begin
            case (op)
                OP_PULSE: begin
                    if (lead) begin
                        c_d.stg   = tbase;
                        c_d.armed = 1'b1;
                    end else if (trail && c_q.armed) begin
                        c_d.a    = tbase;
                        set_flag = 1'b1;
                        if (!blk) begin
                            c_d.b = c_q.stg;
                        end
                    end
                end
                OP_PERIOD: begin
                    if (lead) begin
                        c_d.a     = tbase;
                        c_d.stg   = tbase;
                        c_d.armed = 1'b1;
                        set_flag  = c_q.armed;
                        if (!blk) begin
                            c_d.b = c_q.stg;
                        end
                    end
                end
                default: begin
                end
            endcase
        end

        if (set_flag) begin
            c_d.flag = 1'b1;
        end else if (flag_clr || chg) begin
            c_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cap_a    = c_q.a;
    assign cap_b    = c_q.b;
    assign flag     = c_q.flag;
    assign mode_chg = chg;

endmodule

// File: rtl/dual_capture_channel.sv
module dual_capture_channel #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sig_in,
    input  logic [W-1:0] tbase,
    input  logic [6:0]   mode_sel,
    input  logic         pol,
    input  logic         flag_clr,
    input  logic         rd_a,
    input  logic         rd_b,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         flag
);

    logic ed_rise, ed_fall;
    logic lock_blk, lock_on, mode_chg;

    cap_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_in(sig_in),
        .rise  (ed_rise),
        .fall  (ed_fall)
    );

    cap_rdlock u_lock (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .clr  (mode_chg),
        .blk  (lock_blk),
        .lock (lock_on)
    );

    cap_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tbase   (tbase),
        .mode_sel(mode_sel),
        .pol     (pol),
        .rise    (ed_rise),
        .fall    (ed_fall),
        .flag_clr(flag_clr),
        .blk     (lock_blk),
        .cap_a   (cap_a),
        .cap_b   (cap_b),
        .flag    (flag),
        .mode_chg(mode_chg)
    );

endmodule

// File: rtl/dual_capture_channel_chk.sv
module dual_capture_channel_chk
    import cap_pkg::*;
#(
    parameter int W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_sel,
    input logic              pol,
    input logic              flag_clr,
    input logic              rd_a,
    input logic              lock_on,
    input logic              ed_rise,
    input logic              ed_fall,
    input logic [W-1:0]      cap_a,
    input logic [W-1:0]      cap_b,
    input logic              flag
);

    logic [MODE_W-1:0] mode_last;
    logic              bad_mode, same_mode, wrong_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_last <= '0;
        end else begin
            mode_last <= mode_sel;
        end
    end

    assign bad_mode   = (mode_sel != MODE_PULSE) && (mode_sel != MODE_PERIOD);
    assign same_mode  = (mode_sel == mode_last);
    assign wrong_edge = (mode_sel == MODE_PERIOD) && ((pol && ed_fall) || (!pol && ed_rise));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |=> ($stable(cap_a) && $stable(cap_b) && !flag));

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr && same_mode) |=> flag);

    a_r4_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ed_rise || ed_fall));

    a_r8_b_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_on || rd_a) |=> $stable(cap_b));

    a_r5_wrong_edge: assert property (@(posedge clk) disable iff (!rst_n)
        wrong_edge |=> $stable(cap_a));

    a_r10_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        !same_mode |=> (!flag && !lock_on));

endmodule

bind dual_capture_channel dual_capture_channel_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .pol     (pol),
    .flag_clr(flag_clr),
    .rd_a    (rd_a),
    .lock_on (lock_on),
    .ed_rise (ed_rise),
    .ed_fall (ed_fall),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .flag    (flag)
);

// File: tb/sim_dual_capture_channel.sv
module sim_dual_capture_channel;

    localparam int W = 24;
    localparam logic [6:0] PW  = 7'b0000100;
    localparam logic [6:0] PM  = 7'b0000101;
    localparam logic [6:0] BAD = 7'b0000110;

    typedef struct packed {
        logic [6:0]   m;
        logic         p;
        logic         s;
        logic [W-1:0] tb;
        logic         c;
        logic         ra;
        logic         rb;
        logic [W-1:0] ea;
        logic [W-1:0] eb;
        logic         ef;
        logic [7:0]   rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{PW, 1'b1, 1'b0, 24'h000010, 1'b0, 1'b0, 1'b0, 24'h0,      24'h0,      1'b0, 8'd11}, // R11 quiet line
        '{PW, 1'b0, 1'b1, 24'h000100, 1'b0, 1'b0, 1'b0, 24'h0,      24'h0,      1'b0, 8'd3},  // R3 trailing, unarmed
        '{PW, 1'b0, 1'b0, 24'h000200, 1'b0, 1'b0, 1'b0, 24'h0,      24'h0,      1'b0, 8'd2},  // R2 leading (falling)
        '{PW, 1'b0, 1'b1, 24'h000350, 1'b0, 1'b0, 1'b0, 24'h000350, 24'h000200, 1'b1, 8'd4},  // R4 R12
        '{PW, 1'b0, 1'b1, 24'h000350, 1'b1, 1'b0, 1'b0, 24'h000350, 24'h000200, 1'b0, 8'd9},  // R9 clear
        '{PW, 1'b1, 1'b0, 24'h000400, 1'b0, 1'b0, 1'b0, 24'h000400, 24'h000200, 1'b1, 8'd12}, // R12 falling trails
        '{PW, 1'b1, 1'b1, 24'h000500, 1'b0, 1'b0, 1'b0, 24'h000400, 24'h000200, 1'b1, 8'd2},  // R2 leading (rising)
        '{PW, 1'b1, 1'b0, 24'h000650, 1'b0, 1'b0, 1'b0, 24'h000650, 24'h000500, 1'b1, 8'd7},  // R7
        '{PW, 1'b1, 1'b1, 24'h000700, 1'b0, 1'b1, 1'b0, 24'h000650, 24'h000500, 1'b1, 8'd8},  // R8 lock
        '{PW, 1'b1, 1'b0, 24'h000820, 1'b0, 1'b0, 1'b0, 24'h000820, 24'h000500, 1'b1, 8'd8},  // R8 B held
        '{PW, 1'b1, 1'b0, 24'h000820, 1'b0, 1'b0, 1'b1, 24'h000820, 24'h000500, 1'b1, 8'd8},  // R8 unlock
        '{PW, 1'b1, 1'b1, 24'h000900, 1'b0, 1'b0, 1'b0, 24'h000820, 24'h000500, 1'b1, 8'd2},  // R2
        '{PW, 1'b1, 1'b0, 24'h000950, 1'b0, 1'b0, 1'b0, 24'h000950, 24'h000900, 1'b1, 8'd8},  // R8 resumed
        '{PM, 1'b1, 1'b0, 24'h001000, 1'b0, 1'b0, 1'b0, 24'h000950, 24'h000900, 1'b0, 8'd10}, // R10
        '{PM, 1'b1, 1'b1, 24'h001100, 1'b0, 1'b0, 1'b0, 24'h001100, 24'h000900, 1'b0, 8'd6},  // R6 first
        '{PM, 1'b1, 1'b0, 24'h001200, 1'b0, 1'b0, 1'b0, 24'h001100, 24'h000900, 1'b0, 8'd5},  // R5 ignored
        '{PM, 1'b1, 1'b1, 24'h001250, 1'b0, 1'b0, 1'b0, 24'h001250, 24'h001100, 1'b1, 8'd6},  // R6 second
        '{PM, 1'b1, 1'b0, 24'h001300, 1'b1, 1'b0, 1'b0, 24'h001250, 24'h001100, 1'b0, 8'd9},  // R9
        '{PM, 1'b1, 1'b1, 24'h001525, 1'b0, 1'b0, 1'b0, 24'h001525, 24'h001250, 1'b1, 8'd6},  // R6
        '{PM, 1'b0, 1'b0, 24'h001600, 1'b0, 1'b0, 1'b0, 24'h001600, 24'h001525, 1'b1, 8'd5},  // R5 falling
        '{BAD,1'b0, 1'b1, 24'h001700, 1'b0, 1'b0, 1'b0, 24'h001600, 24'h001525, 1'b0, 8'd11}, // R11
        '{BAD,1'b0, 1'b0, 24'h001800, 1'b0, 1'b0, 1'b0, 24'h001600, 24'h001525, 1'b0, 8'd11}, // R11
        '{PM, 1'b0, 1'b1, 24'h001900, 1'b0, 1'b0, 1'b0, 24'h001600, 24'h001525, 1'b0, 8'd10}, // R10
        '{PM, 1'b0, 1'b0, 24'h001A00, 1'b0, 1'b0, 1'b0, 24'h001A00, 24'h001600, 1'b0, 8'd10}, // R10 first again
        '{PM, 1'b0, 1'b1, 24'h001A80, 1'b0, 1'b0, 1'b0, 24'h001A00, 24'h001600, 1'b0, 8'd5},  // R5
        '{PM, 1'b0, 1'b0, 24'h001B00, 1'b0, 1'b0, 1'b0, 24'h001B00, 24'h001A00, 1'b1, 8'd6},  // R6
        '{PM, 1'b0, 1'b1, 24'h001B80, 1'b0, 1'b0, 1'b0, 24'h001B00, 24'h001A00, 1'b1, 8'd5}   // R5
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sig_in = 1'b0;
    logic [W-1:0] tbase = '0;
    logic [6:0]   mode_sel = PW;
    logic         pol = 1'b1;
    logic         flag_clr = 1'b0;
    logic         rd_a = 1'b0;
    logic         rd_b = 1'b0;
    logic [W-1:0] cap_a, cap_b;
    logic         flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_capture_channel #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tbase(tbase),
        .mode_sel(mode_sel), .pol(pol), .flag_clr(flag_clr),
        .rd_a(rd_a), .rd_b(rd_b), .cap_a(cap_a), .cap_b(cap_b), .flag(flag)
    );

    task automatic check(input logic [W-1:0] ea, input logic [W-1:0] eb,
                         input logic ef, input string tag);
        checks++;
        if (cap_a !== ea || cap_b !== eb || flag !== ef) begin
            errors++;
            $display("FAIL %s: a=%h b=%h flag=%b expected a=%h b=%h flag=%b",
                     tag, cap_a, cap_b, flag, ea, eb, ef);
        end
    endtask

    task automatic run_step(input logic [6:0] m, input logic p, input logic s,
                            input logic [W-1:0] tb, input logic c, input logic ra,
                            input logic rb, input logic [W-1:0] ea,
                            input logic [W-1:0] eb, input logic ef, input string tag);
        @(negedge clk);
        mode_sel = m; pol = p; sig_in = s; tbase = tb;
        flag_clr = c; rd_a = ra; rd_b = rb;
        @(negedge clk);
        flag_clr = 1'b0; rd_a = 1'b0; rd_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ea, eb, ef, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check('0, '0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check('0, '0, 1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            run_step(VECS[i].m, VECS[i].p, VECS[i].s, VECS[i].tb, VECS[i].c,
                     VECS[i].ra, VECS[i].rb, VECS[i].ea, VECS[i].eb, VECS[i].ef,
                     $sformatf("R%0d vector %0d", VECS[i].rq, i));
        end

        // R9: clear strobe in the same cycle as a flag-setting capture
        @(negedge clk);
        sig_in = 1'b0; tbase = 24'h001C00;
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check(24'h001C00, 24'h001B00, 1'b1, "R9 set beats clear");

        // R10: lock taken in period mode, then dropped by the mode change
        run_step(PM, 1'b0, 1'b0, 24'h001C00, 1'b0, 1'b1, 1'b0,
                 24'h001C00, 24'h001B00, 1'b1, "R8 lock taken");
        run_step(PW, 1'b0, 1'b0, 24'h002000, 1'b0, 1'b0, 1'b0,
                 24'h001C00, 24'h001B00, 1'b0, "R10 switch to pulse");
        run_step(PW, 1'b0, 1'b1, 24'h002050, 1'b0, 1'b0, 1'b0,
                 24'h001C00, 24'h001B00, 1'b0, "R3 unarmed after switch");
        run_step(PW, 1'b0, 1'b0, 24'h002100, 1'b0, 1'b0, 1'b0,
                 24'h001C00, 24'h001B00, 1'b0, "R2 leading");
        run_step(PW, 1'b0, 1'b1, 24'h002200, 1'b0, 1'b0, 1'b0,
                 24'h002200, 24'h002100, 1'b1, "R10 lock cleared, B moves");

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check('0, '0, 1'b0, "R1 mid-run reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule